// File: doc/BRIEF.md
# Add/Subtract Unit with Status Flags

This block is a two's-complement adder/subtractor that returns a result word together with four status flags: carry, sign, zero and overflow. A single select bit chooses addition or subtraction. Subtraction feeds the inverted second operand into the same adder with a carry-in of one. The same datapath therefore serves signed and unsigned operands. The consumer chooses which flag it reads as the out-of-range indicator: carry for unsigned operands, overflow for signed ones.

The result is combinational. The flags come in one of two forms, chosen by a parameter. They can be combinational and valid in the same cycle as the result. They can instead be held in a register that loads only when a capture strobe is high at a clock edge. The datapath has no stalls and no storage apart from that optional flag register, so the block applies no back-pressure and needs no valid/ready pair. The operands, the select and the strobe are plain level inputs.

Top module: `addsub_flags`

## Requirements
- R1: With `op_sub` = 0, `result` equals (`dst` + `src`) modulo 2^WIDTH.
- R2: With `op_sub` = 1, `result` equals `dst` + (~`src`) + 1 modulo 2^WIDTH, which is `dst` − `src` wrapped.
- R3: The carry flag is bit WIDTH of the unsigned (WIDTH+1)-bit raw sum. On addition it is 1 when the unsigned sum exceeds 2^WIDTH−1. On subtraction it is 1 when `dst` ≥ `src` unsigned (no borrow) and 0 when a borrow occurs.
- R4: The sign flag equals bit WIDTH−1 of `result`.
- R5: The zero flag is 1 exactly when every bit of `result` is 0.
- R6: The overflow flag is 1 when the two top bits of the sum formed from operands extended by one copy of their sign bit differ. This holds exactly when the signed result lies outside −2^(WIDTH−1) .. 2^(WIDTH−1)−1.
- R7: With REG_FLAGS = 1, the four flag outputs read 0 after reset. They load the current flags at a rising clock edge when `flag_en` is 1, and they hold their value when `flag_en` is 0.
- R8: With REG_FLAGS = 0, the flag outputs follow the operands in the same cycle as `result`, with no clock involved.
- R9: With WIDTH = 8, 0x86 minus 0xF6 gives 0x90 with carry 0, sign 1, zero 0 and overflow 0. 0xBF plus 0xB2 gives 0x71 with carry 1, sign 0, zero 0 and overflow 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional flag register |
| rst_n | input | 1 | Active-low asynchronous reset of the flag register |
| op_sub | input | 1 | Operation select: 0 adds, 1 subtracts |
| dst | input | WIDTH | First operand (minuend on subtraction) |
| src | input | WIDTH | Second operand (subtrahend on subtraction) |
| flag_en | input | 1 | Capture strobe for the registered flags |
| result | output | WIDTH | Sum or difference |
| flag_c | output | 1 | Carry out of the raw sum (1 = no borrow on subtraction) |
| flag_s | output | 1 | Sign: top bit of the result |
| flag_z | output | 1 | Zero: result is all zeros |
| flag_v | output | 1 | Signed overflow from the double-sign-bit sum |

## Verification
The bench builds two copies at WIDTH = 8: one with REG_FLAGS = 1 and one with REG_FLAGS = 0, both driven from the same operands. The combinational copy allows every result and flag to be checked in the same cycle against an integer model that works from unsigned and signed ranges. The registered copy exposes reset values, loading on the strobe, and holding across many operand changes with the strobe low. The 8-bit width places both signed overflow directions, borrow on subtraction, and wrap to zero within reach of the worked examples and a strided sweep of operand pairs.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic v;
  } addsub_flags_t;
endpackage

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int WIDTH = 8
) (
  input  logic             op_sub,
  input  logic [WIDTH-1:0] dst,
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             ovf
);
  localparam int XW = WIDTH + 1;

  logic [WIDTH-1:0] b_opnd;
  logic [XW-1:0]    raw_sum;
  logic [XW-1:0]    dbl_sum;

  // Subtraction: invert the second operand and inject a carry-in of one.
  assign b_opnd  = op_sub ? ~src : src;
  assign raw_sum = {1'b0, dst} + {1'b0, b_opnd} + XW'(op_sub);
  // Sign-extended sum: its two top bits disagree on signed overflow.
  assign dbl_sum = {dst[WIDTH-1], dst} + {b_opnd[WIDTH-1], b_opnd} + XW'(op_sub);

  assign sum   = raw_sum[WIDTH-1:0];
  assign carry = raw_sum[WIDTH];
  assign ovf   = dbl_sum[WIDTH] ^ dbl_sum[WIDTH-1];
endmodule

// File: rtl/addsub_flag_gen.sv
module addsub_flag_gen
  import addsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] sum,
  input  logic             carry,
  input  logic             ovf,
  output addsub_flags_t    flags
);
  always_comb begin
    flags.c = carry;
    flags.s = sum[WIDTH-1];
    flags.z = (sum == '0);
    flags.v = ovf;
  end
endmodule

// File: rtl/addsub_flag_reg.sv
module addsub_flag_reg
  import addsub_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  addsub_flags_t d,
  output addsub_flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d)));
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
  import addsub_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter bit REG_FLAGS = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_sub,
  input  logic [WIDTH-1:0] dst,
  input  logic [WIDTH-1:0] src,
  input  logic             flag_en,
  output logic [WIDTH-1:0] result,
  output logic             flag_c,
  output logic             flag_s,
  output logic             flag_z,
  output logic             flag_v
);
  logic          carry;
  logic          ovf;
  addsub_flags_t live_flags;
  addsub_flags_t out_flags;

  addsub_core #(.WIDTH(WIDTH)) u_core (
    .op_sub(op_sub), .dst(dst), .src(src),
    .sum(result), .carry(carry), .ovf(ovf)
  );

  addsub_flag_gen #(.WIDTH(WIDTH)) u_flag_gen (
    .sum(result), .carry(carry), .ovf(ovf), .flags(live_flags)
  );

  generate
    if (REG_FLAGS) begin : g_reg
      addsub_flag_reg u_flag_reg (
        .clk(clk), .rst_n(rst_n), .load(flag_en),
        .d(live_flags), .q(out_flags)
      );
    end else begin : g_comb
      assign out_flags = live_flags;
    end
  endgenerate

  assign flag_c = out_flags.c;
  assign flag_s = out_flags.s;
  assign flag_z = out_flags.z;
  assign flag_v = out_flags.v;

  assert_add_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !op_sub |-> (result == WIDTH'(dst + src)));
  assert_sub_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_sub |-> (result == WIDTH'(dst - src)));
  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    live_flags.z == (result == '0));
  assert_sign_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    live_flags.s == result[WIDTH-1]);
  assert_sub_borrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_sub |-> (live_flags.c == (dst >= src)));
endmodule

// File: tb/test_addsub_flags.sv
module test_addsub_flags;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_sub = 1'b0;
  logic [W-1:0] dst = '0;
  logic [W-1:0] src = '0;
  logic         flag_en = 1'b0;

  logic [W-1:0] r_res, c_res;
  logic r_c, r_s, r_z, r_v, c_c, c_s, c_z, c_v;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  addsub_flags #(.WIDTH(W), .REG_FLAGS(1'b1)) i_addsub_flags (
    .clk(clk), .rst_n(rst_n), .op_sub(op_sub), .dst(dst), .src(src),
    .flag_en(flag_en), .result(r_res),
    .flag_c(r_c), .flag_s(r_s), .flag_z(r_z), .flag_v(r_v)
  );

  addsub_flags #(.WIDTH(W), .REG_FLAGS(1'b0)) i_addsub_flags_comb (
    .clk(clk), .rst_n(rst_n), .op_sub(op_sub), .dst(dst), .src(src),
    .flag_en(1'b0), .result(c_res),
    .flag_c(c_c), .flag_s(c_s), .flag_z(c_z), .flag_v(c_v)
  );

  // Reference model: {result, c, s, z, v}, computed from integer ranges.
  function automatic logic [W+3:0] model(input logic sub, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    int ua = int'(a);
    int ub = int'(b);
    int sa = ua >= 128 ? ua - 256 : ua;
    int sb = ub >= 128 ? ub - 256 : ub;
    int ur = sub ? ua - ub : ua + ub;
    int sr = sub ? sa - sb : sa + sb;
    logic [W-1:0] res = W'(ur);
    logic cf = sub ? (ua >= ub) : (ur > 255);
    logic vf = (sr > 127) || (sr < -128);
    return {res, cf, res[W-1], res == 0, vf};
  endfunction

  task automatic check(input string tag, input logic [W+3:0] act,
                       input logic [W+3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual res=%h cszv=%b expected res=%h cszv=%b",
               tag, act[W+3:4], act[3:0], exp[W+3:4], exp[3:0]);
    end
  endtask

  task automatic apply(input logic sub, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    op_sub = sub; dst = a; src = b;
    #1;
  endtask

  task automatic t_reset;
    check("R7 reset flags", {r_res, r_c, r_s, r_z, r_v}, {r_res, 4'b0000});
  endtask

  task automatic t_examples;
    apply(1'b1, 8'h86, 8'hF6);
    check("R9 sub example", {c_res, c_c, c_s, c_z, c_v}, {8'h90, 4'b0100});
    apply(1'b0, 8'hBF, 8'hB2);
    check("R9 add example", {c_res, c_c, c_s, c_z, c_v}, {8'h71, 4'b1001});
  endtask

  task automatic t_add_patterns;
    apply(1'b0, 8'h7F, 8'h01);
    check("R1 R6 positive overflow", {c_res, c_c, c_s, c_z, c_v}, model(1'b0, 8'h7F, 8'h01));
    apply(1'b0, 8'hFF, 8'h01);
    check("R1 R3 R5 wrap to zero", {c_res, c_c, c_s, c_z, c_v}, {8'h00, 4'b1010});
    apply(1'b0, 8'h12, 8'h34);
    check("R1 R4 plain add", {c_res, c_c, c_s, c_z, c_v}, {8'h46, 4'b0000});
  endtask

  task automatic t_sub_patterns;
    apply(1'b1, 8'h05, 8'h05);
    check("R2 R3 R5 equal operands", {c_res, c_c, c_s, c_z, c_v}, {8'h00, 4'b1010});
    apply(1'b1, 8'h03, 8'h04);
    check("R2 R3 R4 borrow", {c_res, c_c, c_s, c_z, c_v}, {8'hFF, 4'b0100});
    apply(1'b1, 8'h80, 8'h01);
    check("R2 R6 negative overflow", {c_res, c_c, c_s, c_z, c_v}, {8'h7F, 4'b1001});
  endtask

  task automatic t_capture_hold;
    logic [W+3:0] m;
    m = model(1'b1, 8'h86, 8'hF6);
    @(negedge clk);
    op_sub = 1'b1; dst = 8'h86; src = 8'hF6; flag_en = 1'b1;
    @(negedge clk);
    flag_en = 1'b0;
    #1;
    check("R7 capture", {r_res, r_c, r_s, r_z, r_v}, m);
    for (int i = 0; i < 6; i++) apply(1'b0, W'(i * 41), 8'hB2);
    @(negedge clk);
    #1;
    check("R7 hold with strobe low", {8'h00, r_c, r_s, r_z, r_v}, {8'h00, m[3:0]});
    check("R8 comb follows operands", {c_res, c_c, c_s, c_z, c_v},
          model(1'b0, W'(5 * 41), 8'hB2));
  endtask

  task automatic t_sweep;
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 256; a += 7)
        for (int b = 0; b < 256; b += 5) begin
          apply(s[0], W'(a), W'(b));
          check(s[0] ? "R2 R3 R4 R5 R6 sweep sub" : "R1 R3 R4 R5 R6 sweep add",
                {c_res, c_c, c_s, c_z, c_v}, model(s[0], W'(a), W'(b)));
          check("R8 registered copy result", {r_res, 4'b0000}, {c_res, 4'b0000});
        end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_examples();
    t_add_patterns();
    t_sub_patterns();
    t_capture_hold();
    t_sweep();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule